// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It decides when an embedded program or erase has finished. Software or a command engine pulses `start` once the last write strobe of the program or erase command has risen. The pulse carries a valid address inside the target region and a choice of which toggle bit to watch.

After the pulse, the poller reads the status word at that one address in pairs, through a request/acknowledge read port. It compares the chosen toggle bit between the two reads of a pair. While the bit keeps changing it watches the time-limit-exceeded flag, bit 5 of the status word.

The poller ends in one of three ways:
- **Done.** The toggle bit is steady across a pair.
- **Fail.** The toggle bit still changes on one extra confirming pair, read after bit 5 was seen high. The poller first writes the reset command to the device to return it to array reads, then reports failure.
- **Timeout.** A programmable number of toggling pairs with bit 5 low runs out. This is an error kept apart from the device-side failure.

Alongside this, the poller classifies the addressed sector. It compares how bit 6 and bit 2 behaved in the latest pair and reports the sector as idle, actively erasing, or selected for erase while the erase is suspended.

Top module: `tglpoll_top`

## Requirements
- R1: After reset, the outputs are quiet:
  - `busy`, `done`, `fail`, `tmo`, `rd_req` and `wr_req` are 0.
  - `sect_state` is 2'b00.
- R2: A `start` pulse seen while idle has these effects:
  - `busy` goes high on the next cycle.
  - `busy` stays high until the cycle in which a result pulse (`done`, `fail` or `tmo`) is high.
  - In that result cycle `busy` is low.
- R3: Every status read goes to the address captured with `start`.
  - The read request and address are held until `rd_ack`.
  - Reads come strictly in pairs.
- R4: A pair whose toggle bit is equal in both reads ends the run with `done`. It costs exactly two reads.
- R5: In a pair whose toggle bit differs and whose second word has bit 5 low, the poller reads another pair. This holds only while the pair limit allows.
- R6: In a pair whose toggle bit differs and whose second word has bit 5 high, the poller reads one more confirming pair. If that confirming pair is steady, the result is `done`.
- R7: If the confirming pair still toggles, the poller issues one write request with data 8'hF0 to the captured address. The `fail` pulse comes in the cycle after that write is acknowledged.
- R8: `sel_dq2` = 0 selects bit 6 as the toggle bit. `sel_dq2` = 1 selects bit 2.
- R9: After `pair_limit` consecutive toggling pairs, all with bit 5 low, the poller pulses `tmo`.
  - It issues no write.
  - Bit 5 high takes precedence over the limit.
  - `pair_limit` must be at least 1.
- R10: `sect_state` is updated after every pair and then held:
  - 2'b01 when bit 6 changed within the pair.
  - 2'b10 when bit 6 was steady and bit 2 changed.
  - 2'b00 when neither changed.
- R11: `done`, `fail` and `tmo` each last one cycle, and never more than one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted when idle) |
| addr_in | input | AW | Valid address to poll |
| sel_dq2 | input | 1 | 0: watch bit 6, 1: watch bit 2 |
| pair_limit | input | CW | Maximum toggling pairs before timeout |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Status read address |
| rd_ack | input | 1 | Read completes, `rd_data` valid |
| rd_data | input | DW | Status word returned |
| wr_req | output | 1 | Reset-command write request |
| wr_addr | output | AW | Reset-command write address |
| wr_data | output | DW | Reset-command data (8'hF0) |
| wr_ack | input | 1 | Write completes |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| tmo | output | 1 | One-cycle pair-limit timeout pulse |
| sect_state | output | 2 | Sector classification |

## Verification
The assertions assume three things about the inputs:
- `rd_ack` and `wr_ack` are asserted only while the matching request is high.
- `start` is pulsed only while the block is idle.
- The reset is held low from time zero.

The bench's device model acknowledges only a pending request, after zero to two wait cycles. It launches each run only after the previous result pulse has cleared.

The stimulus sweeps a small grid:
- device mode: unselected sector, selected and erasing, selected and suspended;
- toggle-bit choice;
- the number of reads for which the device keeps toggling;
- the read index at which bit 5 rises;
- two pair limits.

From each point of the grid the bench derives the result, the read count and the sector state arithmetically.

// File: rtl/poll_pkg.sv
package poll_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_EVAL,
      ST_WRST
   } poll_st_t;

   typedef enum logic [1:0] {
      SECT_QUIET = 2'b00,
      SECT_ERASE = 2'b01,
      SECT_SUSP  = 2'b10
   } sect_t;

   localparam int unsigned STATUS_BITS = 8;

endpackage

// File: rtl/tgl_cmp.sv
module tgl_cmp #(
   parameter int unsigned DW      = 8,
   parameter int unsigned POS_T6  = 6,
   parameter int unsigned POS_T2  = 2,
   parameter int unsigned POS_LIM = 5
) (
   input  logic [DW-1:0] first_w,
   input  logic [DW-1:0] second_w,
   input  logic          sel_t2,
   output logic          tgl_sel,
   output logic          tgl6,
   output logic          tgl2,
   output logic          lim_hi
);

   logic [DW-1:0] diff;
   logic          unused_rest;

   for (genvar b = 0; b < DW; b++) begin : g_diff
      assign diff[b] = first_w[b] ^ second_w[b];
   end

   assign tgl6        = diff[POS_T6];
   assign tgl2        = diff[POS_T2];
   assign tgl_sel     = sel_t2 ? tgl2 : tgl6;
   assign lim_hi      = second_w[POS_LIM];
   assign unused_rest = ^diff;

endmodule

// File: rtl/sect_class.sv
module sect_class
   import poll_pkg::*;
#(
   parameter bit CLR_ON_START = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic       clr,
   input  logic       tgl6,
   input  logic       tgl2,
   output logic [1:0] sect_state
);

   sect_t nxt;
   sect_t cur;

   always_comb begin
      if (tgl6)      nxt = SECT_ERASE;
      else if (tgl2) nxt = SECT_SUSP;
      else           nxt = SECT_QUIET;
   end

   if (CLR_ON_START) begin : g_clr
      always_ff @(posedge clk) begin
         if (!rst_n)   cur <= SECT_QUIET;
         else if (upd) cur <= nxt;
         else if (clr) cur <= SECT_QUIET;
      end
   end else begin : g_hold
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk) begin
         if (!rst_n)   cur <= SECT_QUIET;
         else if (upd) cur <= nxt;
      end
   end

   assign sect_state = cur;

endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
   import poll_pkg::*;
#(
   parameter int unsigned AW       = 8,
   parameter int unsigned DW       = 8,
   parameter int unsigned CW       = 8,
   parameter logic [7:0]  RST_CODE = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr_in,
   input  logic          sel_dq2,
   input  logic [CW-1:0] pair_limit,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [DW-1:0] rd_data,
   output logic          wr_req,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_ack,
   output logic [DW-1:0] first_q,
   output logic [DW-1:0] second_q,
   output logic          sel_q,
   input  logic          tgl_sel,
   input  logic          lim_hi,
   output logic          eval_o,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic          tmo
);

   localparam int unsigned CNTW = CW + 1;

   poll_st_t       st;
   logic [AW-1:0]  addr_q;
   logic [CW-1:0]  limit_q;
   logic [CW-1:0]  pairs;
   logic           rchk;
   logic           last_pair;

   assign last_pair = (CNTW'(pairs) + CNTW'(1)) >= CNTW'(limit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         addr_q   <= '0;
         limit_q  <= '0;
         sel_q    <= 1'b0;
         pairs    <= '0;
         rchk     <= 1'b0;
         first_q  <= '0;
         second_q <= '0;
         done     <= 1'b0;
         fail     <= 1'b0;
         tmo      <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         tmo  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  addr_q  <= addr_in;
                  limit_q <= pair_limit;
                  sel_q   <= sel_dq2;
                  pairs   <= '0;
                  rchk    <= 1'b0;
                  st      <= ST_RD_A;
               end
            end
            ST_RD_A: begin
               if (rd_ack) begin
                  first_q <= rd_data;
                  st      <= ST_RD_B;
               end
            end
            ST_RD_B: begin
               if (rd_ack) begin
                  second_q <= rd_data;
                  st       <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (!tgl_sel) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else if (rchk) begin
                  st <= ST_WRST;
               end else if (lim_hi) begin
                  rchk <= 1'b1;
                  st   <= ST_RD_A;
               end else if (last_pair) begin
                  tmo <= 1'b1;
                  st  <= ST_IDLE;
               end else begin
                  pairs <= pairs + 1'b1;
                  st    <= ST_RD_A;
               end
            end
            ST_WRST: begin
               if (wr_ack) begin
                  fail <= 1'b1;
                  st   <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rd_req  = (st == ST_RD_A) || (st == ST_RD_B);
   assign rd_addr = addr_q;
   assign wr_req  = (st == ST_WRST);
   assign wr_addr = addr_q;
   assign wr_data = DW'(RST_CODE);
   assign eval_o  = (st == ST_EVAL);
   assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/tglpoll_top.sv
module tglpoll_top
   import poll_pkg::*;
#(
   parameter int unsigned AW           = 8,
   parameter int unsigned DW           = 8,
   parameter int unsigned CW           = 8,
   parameter int unsigned POS_T6       = 6,
   parameter int unsigned POS_T2       = 2,
   parameter int unsigned POS_LIM      = 5,
   parameter logic [7:0]  RST_CODE     = 8'hF0,
   parameter bit          CLR_ON_START = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr_in,
   input  logic          sel_dq2,
   input  logic [CW-1:0] pair_limit,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [DW-1:0] rd_data,
   output logic          wr_req,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_ack,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic          tmo,
   output logic [1:0]    sect_state
);

   if (DW < STATUS_BITS) begin : g_bad_dw
      $error("tglpoll_top: DW must be at least 8");
   end
   if (POS_T6 >= DW || POS_T2 >= DW || POS_LIM >= DW) begin : g_bad_pos
      $error("tglpoll_top: status bit position outside data width");
   end
   if (AW < 1 || CW < 1) begin : g_bad_w
      $error("tglpoll_top: AW and CW must be nonzero");
   end

   logic [DW-1:0] first_q;
   logic [DW-1:0] second_q;
   logic          sel_q;
   logic          tgl_sel;
   logic          tgl6;
   logic          tgl2;
   logic          lim_hi;
   logic          eval_o;

   poll_fsm #(
      .AW(AW), .DW(DW), .CW(CW), .RST_CODE(RST_CODE)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
      .sel_dq2(sel_dq2), .pair_limit(pair_limit),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .first_q(first_q), .second_q(second_q), .sel_q(sel_q),
      .tgl_sel(tgl_sel), .lim_hi(lim_hi), .eval_o(eval_o),
      .busy(busy), .done(done), .fail(fail), .tmo(tmo)
   );

   tgl_cmp #(
      .DW(DW), .POS_T6(POS_T6), .POS_T2(POS_T2), .POS_LIM(POS_LIM)
   ) u_cmp (
      .first_w(first_q), .second_w(second_q), .sel_t2(sel_q),
      .tgl_sel(tgl_sel), .tgl6(tgl6), .tgl2(tgl2), .lim_hi(lim_hi)
   );

   sect_class #(
      .CLR_ON_START(CLR_ON_START)
   ) u_sect (
      .clk(clk), .rst_n(rst_n), .upd(eval_o), .clr(start && !busy),
      .tgl6(tgl6), .tgl2(tgl2), .sect_state(sect_state)
   );

endmodule

// File: rtl/poll_chk.sv
module poll_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic fail,
   input logic tmo,
   input logic rd_req,
   input logic rd_ack,
   input logic wr_req,
   input logic wr_ack
);

   // R11
   result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fail, tmo}));

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R2
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || fail || tmo));

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> rd_req);

   // R7
   fail_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> $past(wr_req && wr_ack));

   // R7
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

endmodule

bind tglpoll_top poll_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .done(done), .fail(fail), .tmo(tmo),
   .rd_req(rd_req), .rd_ack(rd_ack), .wr_req(wr_req), .wr_ack(wr_ack)
);

// File: tb/tglpoll_top_bench.sv
`timescale 1ns/1ps
module tglpoll_top_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] addr_in = '0;
   logic       sel_dq2 = 1'b0;
   logic [7:0] pair_limit = 8'd1;
   logic       rd_req;
   logic [7:0] rd_addr;
   logic       rd_ack = 1'b0;
   logic [7:0] rd_data = '0;
   logic       wr_req;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic       wr_ack = 1'b0;
   logic       busy, done, fail, tmo;
   logic [1:0] sect_state;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // device model controls
   int dev_mode = 0;
   int dev_act  = 0;
   int dev_lim  = 100;
   int dev_lat  = 0;
   int rd_cnt   = 0;
   int wcnt     = 0;
   int wr_cnt   = 0;
   int addr_err = 0;
   logic [7:0] wr_last_d = '0;
   logic [7:0] wr_last_a = '0;

   always #5 clk = ~clk;

   tglpoll_top u_tglpoll_top (
      .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
      .sel_dq2(sel_dq2), .pair_limit(pair_limit),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .busy(busy), .done(done), .fail(fail), .tmo(tmo), .sect_state(sect_state)
   );

   function automatic logic [7:0] stat_word(int i);
      int   p;
      logic b6, b2, b5;
      p  = (i < dev_act) ? i : dev_act;
      b6 = (dev_mode != 2) ? p[0] : 1'b1;
      b2 = (dev_mode != 0) ? p[0] : 1'b0;
      b5 = (i >= dev_lim);
      return {1'b0, b6, b5, 1'b1, 1'b0, b2, 1'b0, 1'b1};
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rd_req && !rd_ack) begin
         if (rd_addr != addr_in) addr_err <= addr_err + 1;
         if (wcnt >= dev_lat) begin
            rd_ack  <= 1'b1;
            rd_data <= stat_word(rd_cnt);
            rd_cnt  <= rd_cnt + 1;
            wcnt    <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         rd_ack <= 1'b0;
      end
      if (wr_req && !wr_ack) begin
         wr_ack    <= 1'b1;
         wr_cnt    <= wr_cnt + 1;
         wr_last_d <= wr_data;
         wr_last_a <= wr_addr;
      end else begin
         wr_ack <= 1'b0;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(negedge clk) begin
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // expected outcome: 0 done, 1 fail, 2 tmo
   task automatic model(input bit sel, input int lim,
                        output int res, output int nrd, output int sect);
      int  i, pairs;
      bit  rc, tg;
      logic [7:0] a, b;
      i = 0; pairs = 0; rc = 0; res = -1; sect = 0;
      while (res < 0) begin
         a = stat_word(i);
         b = stat_word(i + 1);
         i = i + 2;
         sect = (a[6] ^ b[6]) ? 1 : ((a[2] ^ b[2]) ? 2 : 0);
         tg = sel ? (a[2] ^ b[2]) : (a[6] ^ b[6]);
         if (!tg)                  res = 0;
         else if (rc)              res = 1;
         else if (b[5])            rc = 1;
         else if (pairs + 1 >= lim) res = 2;
         else                      pairs = pairs + 1;
      end
      nrd = i;
   endtask

   task automatic run(input int mode, input bit sel, input int act,
                      input int lim5, input int plim, input int lat, input int adr);
      int  eres, enrd, esect, got, n;
      bit  seen;
      @(negedge clk);
      dev_mode = mode; dev_act = act; dev_lim = lim5; dev_lat = lat;
      rd_cnt = 0; wr_cnt = 0; addr_err = 0; wcnt = 0;
      addr_in = adr[7:0]; sel_dq2 = sel; pair_limit = plim[7:0];
      model(sel, plim, eres, enrd, esect);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      seen = 0; n = 0;
      while (!seen && n < 400) begin
         if (done || fail || tmo) seen = 1;
         else begin @(negedge clk); n = n + 1; end
      end
      got = done ? 0 : (fail ? 1 : (tmo ? 2 : -1));
      if (eres == 0)      chk(got == 0, "R4 R6 done outcome", got, eres);
      else if (eres == 1) chk(got == 1, "R7 fail outcome", got, eres);
      else                chk(got == 2, "R9 timeout outcome", got, eres);
      chk(busy == 1'b0, "R2 busy low at result", busy, 0);
      chk(rd_cnt == enrd, sel ? "R5 R8 read count bit2" : "R5 R8 read count bit6", rd_cnt, enrd);
      chk(addr_err == 0, "R3 read address", addr_err, 0);
      chk(sect_state == esect[1:0], "R10 sector state", sect_state, esect);
      chk(wr_cnt == ((eres == 1) ? 1 : 0), "R7 R9 reset write count", wr_cnt, (eres == 1) ? 1 : 0);
      if (eres == 1) begin
         chk(wr_last_d == 8'hF0, "R7 reset data", wr_last_d, 8'hF0);
         chk(wr_last_a == adr[7:0], "R7 reset address", wr_last_a, adr);
      end
      @(negedge clk);
      chk({done, fail, tmo} == 3'b000, "R11 single-cycle pulse", {done, fail, tmo}, 0);
      chk(rd_cnt == enrd, "R4 no extra read after result", rd_cnt, enrd);
   endtask

   initial begin
      int acts[6];
      int lims[4];
      int idx;
      acts = '{0, 1, 2, 3, 5, 8};
      lims = '{0, 2, 4, 100};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1 busy", busy, 0);
      chk({done, fail, tmo} == 0, "R1 result pulses", {done, fail, tmo}, 0);
      chk(rd_req == 0 && wr_req == 0, "R1 requests", {rd_req, wr_req}, 0);
      chk(sect_state == 2'b00, "R1 sector state", sect_state, 0);
      rst_n = 1'b1;
      @(negedge clk);
      idx = 0;
      for (int m = 0; m < 3; m++)
         for (int s = 0; s < 2; s++)
            for (int a = 0; a < 6; a++)
               for (int d = 0; d < 4; d++)
                  for (int l = 0; l < 2; l++) begin
                     run(m, s[0], acts[a], lims[d], (l == 0) ? 1 : 3, idx % 3, (idx * 37 + 5) % 256);
                     idx = idx + 1;
                  end
      summary();
      $finish;
   end

endmodule